// File: doc/BRIEF.md
# Pipelined Memory Line with Deferred Block Reads

This block is one line of a multiport global memory. The line is built as a chain of `LAT` memory modules, where `LAT` is the module access time in clock cycles. Successive accesses go to successive modules in rotation, so the line takes one request every cycle and returns each read a fixed `LAT` cycles after that read is issued.

Storage is organised as variable-length blocks. A small token table holds a base address, a last offset and a full/empty flag for each block. A requester first defines a block, then fills it with writes. The block turns full when its final word is written. A read that names a block which is still empty is not refused and does not return stale data. It is parked on a pending list. Once the block is filled, the parked reads leave the list one per cycle in arrival order. Each response carries the requester's tag, so the requester can match responses that come back out of order.

Top module: `gm_line`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after reset, `rsp_valid_o` is 0, `req_ready_o` is 1 and the pending list is empty.
- R2: A request with op 2 (define) sets the block's base address to `req_data_i[AW-1:0]` and its last offset to `req_off_i`. The block has length `req_off_i+1`. The word at offset o of the block lives at address base+o, modulo 2^AW.
- R3: A request with op 1 (write) stores `req_data_i` at the block's base+offset. The block becomes full only when the accepted offset equals its last offset. Writes to other offsets leave the block empty.
- R4: A request with op 0 (read) to a full block, presented in cycle k while no parked read is released, gives `rsp_valid_o`=1 with the word at base+offset in cycle k+LAT.
- R5: A read to an empty block produces no response until the block becomes full.
- R6: Parked reads are released strictly in arrival order, one per cycle. The first release happens in the cycle after the final write is accepted. Each released read responds LAT cycles after its release cycle.
- R7: When a parked read is released in a cycle, a read presented in that same cycle joins the back of the pending list, even if its block is full.
- R8: The pending list holds PEND reads. When it is full, `req_ready_o` is 0 for reads and stays 1 for writes and defines.
- R9: Every response returns the tag of the read that produced it on `rsp_tag_o`.
- R10: Defining a block again returns it to empty, so later reads to it are parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_op_i | input | 2 | 0 read, 1 write, 2 define block |
| req_blk_i | input | BW | Block id |
| req_off_i | input | LW | Word offset in block (last offset for define) |
| req_data_i | input | DW | Write data, or base address for define |
| req_tag_i | input | TW | Requester tag for reads |
| rsp_valid_o | output | 1 | Read response present |
| rsp_data_o | output | DW | Read data |
| rsp_tag_o | output | TW | Tag of the answered read |

## Verification
A direct read presented in cycle k must show up in cycle k+LAT. A parked read is due LAT cycles after its release, and the first release comes one cycle after the final write is accepted. The bench counts rising edges, drives and samples on falling edges, and logs the cycle in which each tag comes back. Each logged cycle is compared with the cycle derived from these rules. This means an early response fails the check just as a late one does. A missing response also fails. Ready and the absence of responses are checked in the cycles where a parked read must not yet have left.

// File: rtl/gm_line_pkg.sv
package gm_line_pkg;
  typedef enum logic [1:0] {
    OP_RD    = 2'd0,
    OP_WR    = 2'd1,
    OP_ALLOC = 2'd2
  } op_e;
endpackage

// File: rtl/gm_line_tokens.sv
module gm_line_tokens #(
  parameter int NBLK = 4,
  parameter int AW   = 6,
  parameter int LW   = 4,
  localparam int BW  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         alloc_i,
  input  logic                         wr_i,
  input  logic [BW-1:0]                blk_i,
  input  logic [AW-1:0]                base_i,
  input  logic [LW-1:0]                off_i,
  output logic [NBLK-1:0][AW-1:0]      base_o,
  output logic [NBLK-1:0]              full_o
);
  logic [NBLK-1:0][LW-1:0] last_q;

  for (genvar b = 0; b < NBLK; b++) begin : g_tok
    logic sel;
    assign sel = (blk_i == BW'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[b] <= '0;
        last_q[b] <= '0;
        full_o[b] <= 1'b0;
      end else if (alloc_i && sel) begin
        base_o[b] <= base_i;
        last_q[b] <= off_i;
        full_o[b] <= 1'b0;
      end else if (wr_i && sel && off_i == last_q[b]) begin
        full_o[b] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/gm_line_pend.sv
module gm_line_pend #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;

  assign full_o  = (cnt_o == CW'(DEPTH));
  assign empty_o = (cnt_o == '0);
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  // pointers wrap at DEPTH (any depth, not only powers of two)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_o <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop_i)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_o <= cnt_o + CW'(push_i) - CW'(pop_i);
    end
  end
endmodule

// File: rtl/gm_line_store.sv
module gm_line_store #(
  parameter int AW  = 6,
  parameter int DW  = 16,
  parameter int TW  = 4,
  parameter int LAT = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  input  logic [AW-1:0] raddr_i,
  input  logic [TW-1:0] rtag_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o,
  output logic [TW-1:0] rsp_tag_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [LAT-1:0] v_q;
  logic [DW-1:0]  d_q [LAT];
  logic [TW-1:0]  t_q [LAT];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[waddr_i] <= wdata_i;
  end

  // one slot per module; an access advances one module per cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_q[0] <= 1'b0;
    else         v_q[0] <= rd_i;
  end
  always_ff @(posedge clk_i) begin
    d_q[0] <= mem_q[raddr_i];
    t_q[0] <= rtag_i;
  end

  for (genvar s = 1; s < LAT; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) v_q[s] <= 1'b0;
      else         v_q[s] <= v_q[s-1];
    end
    always_ff @(posedge clk_i) begin
      d_q[s] <= d_q[s-1];
      t_q[s] <= t_q[s-1];
    end
  end

  assign rsp_valid_o = v_q[LAT-1];
  assign rsp_data_o  = d_q[LAT-1];
  assign rsp_tag_o   = t_q[LAT-1];
endmodule

// File: rtl/gm_line.sv
module gm_line
  import gm_line_pkg::*;
#(
  parameter int LAT  = 4,
  parameter int NBLK = 4,
  parameter int AW   = 6,
  parameter int LW   = 4,
  parameter int DW   = 16,
  parameter int TW   = 4,
  parameter int PEND = 4,
  localparam int BW  = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int CW  = $clog2(PEND + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_op_i,
  input  logic [BW-1:0] req_blk_i,
  input  logic [LW-1:0] req_off_i,
  input  logic [DW-1:0] req_data_i,
  input  logic [TW-1:0] req_tag_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o,
  output logic [TW-1:0] rsp_tag_o
);
  typedef struct packed {
    logic [BW-1:0] blk;
    logic [LW-1:0] off;
    logic [TW-1:0] tag;
  } pend_t;

  op_e                     op;
  logic                    acc, is_rd, is_wr, is_al;
  logic [NBLK-1:0][AW-1:0] tok_base;
  logic [NBLK-1:0]         tok_full;
  pend_t                   pend_in, head;
  logic [CW-1:0]           pend_cnt;
  logic                    pend_full, pend_empty;
  logic                    rel, direct, push, pop, issue;
  logic [BW-1:0]           iss_blk;
  logic [LW-1:0]           iss_off;
  logic [TW-1:0]           iss_tag;
  logic [AW-1:0]           raddr, waddr;

  assign op          = op_e'(req_op_i);
  assign req_ready_o = !(pend_full && op == OP_RD);
  assign acc         = req_valid_i && req_ready_o;
  assign is_rd       = acc && op == OP_RD;
  assign is_wr       = acc && op == OP_WR;
  assign is_al       = acc && op == OP_ALLOC;

  // parked head goes first; a same-cycle read queues behind it
  assign rel    = !pend_empty && tok_full[head.blk];
  assign direct = is_rd && tok_full[req_blk_i] && !rel;
  assign push   = is_rd && !direct;
  assign pop    = rel;
  assign issue  = rel || direct;

  assign pend_in = '{blk: req_blk_i, off: req_off_i, tag: req_tag_i};
  assign iss_blk = rel ? head.blk : req_blk_i;
  assign iss_off = rel ? head.off : req_off_i;
  assign iss_tag = rel ? head.tag : req_tag_i;
  assign raddr   = tok_base[iss_blk] + AW'(iss_off);
  assign waddr   = tok_base[req_blk_i] + AW'(req_off_i);

  gm_line_tokens #(.NBLK(NBLK), .AW(AW), .LW(LW)) u_tok (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alloc_i (is_al),
    .wr_i    (is_wr),
    .blk_i   (req_blk_i),
    .base_i  (req_data_i[AW-1:0]),
    .off_i   (req_off_i),
    .base_o  (tok_base),
    .full_o  (tok_full)
  );

  gm_line_pend #(.W($bits(pend_t)), .DEPTH(PEND)) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .din_i   (pend_in),
    .pop_i   (pop),
    .dout_o  (head),
    .cnt_o   (pend_cnt),
    .full_o  (pend_full),
    .empty_o (pend_empty)
  );

  gm_line_store #(.AW(AW), .DW(DW), .TW(TW), .LAT(LAT)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (is_wr),
    .waddr_i     (waddr),
    .wdata_i     (req_data_i),
    .rd_i        (issue),
    .raddr_i     (raddr),
    .rtag_i      (iss_tag),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o),
    .rsp_tag_o   (rsp_tag_o)
  );
endmodule

// File: rtl/gm_line_chk.sv
module gm_line_chk #(
  parameter int NBLK = 4,
  parameter int PEND = 4,
  localparam int BW  = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int CW  = $clog2(PEND + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NBLK-1:0] tok_full,
  input logic            is_wr,
  input logic            is_al,
  input logic [BW-1:0]   req_blk_i,
  input logic [CW-1:0]   pend_cnt,
  input logic            push,
  input logic            pop
);
  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pend_cnt) <= PEND);

  // R6
  pend_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pend_cnt) == int'($past(pend_cnt)) + int'($past(push)) - int'($past(pop)));

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    // R3
    full_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(tok_full[b]) |-> $past(is_wr) && $past(req_blk_i) == BW'(b));

    // R10
    full_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(tok_full[b]) |-> $past(is_al) && $past(req_blk_i) == BW'(b));
  end
endmodule

bind gm_line gm_line_chk #(.NBLK(NBLK), .PEND(PEND)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tok_full  (tok_full),
  .is_wr     (is_wr),
  .is_al     (is_al),
  .req_blk_i (req_blk_i),
  .pend_cnt  (pend_cnt),
  .push      (push),
  .pop       (pop)
);

// File: tb/tb_gm_line.sv
module tb_gm_line;
  localparam int CLK_PERIOD = 10;
  localparam int LAT  = 4;
  localparam int NBLK = 4;
  localparam int AW   = 6;
  localparam int LW   = 4;
  localparam int DW   = 16;
  localparam int TW   = 4;
  localparam int PEND = 4;
  localparam int BW   = 2;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          valid = 1'b0, ready;
  logic [1:0]    op = 2'd0;
  logic [BW-1:0] blk = '0;
  logic [LW-1:0] off = '0;
  logic [DW-1:0] wdat = '0;
  logic [TW-1:0] tag = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [TW-1:0] rsp_tag;

  int total = 0, fails = 0, cyc = 0, rcount = 0;
  int got [16];
  int rcyc [16];
  logic [DW-1:0] rdat [16];
  bit done = 0;

  gm_line #(.LAT(LAT), .NBLK(NBLK), .AW(AW), .LW(LW), .DW(DW), .TW(TW), .PEND(PEND)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_op_i(op), .req_blk_i(blk), .req_off_i(off), .req_data_i(wdat),
    .req_tag_i(tag), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_tag_o(rsp_tag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      got[rsp_tag]  = got[rsp_tag] + 1;
      rdat[rsp_tag] = rsp_data;
      rcyc[rsp_tag] = cyc;
      rcount = rcount + 1;
    end
  end

  function automatic logic [DW-1:0] wd(int b, int o);
    return DW'(((b + 1) << 12) | (o << 4) | b);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(logic [1:0] o_p, int b, int o, logic [DW-1:0] d, int t, output int n);
    valid = 1'b1; op = o_p; blk = BW'(b); off = LW'(o); wdat = d; tag = TW'(t);
    n = cyc;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic define(int b, int base, int last);
    int n;
    send(2'd2, b, last, DW'(base), 0, n);
  endtask

  task automatic wr(int b, int o, logic [DW-1:0] d, output int n);
    send(2'd1, b, o, d, 0, n);
  endtask

  task automatic rd(int b, int o, int t, output int n);
    send(2'd0, b, o, '0, t, n);
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic exp_rsp(int t, logic [DW-1:0] d, int c, string req);
    chk(got[t] == 1, {req, " count"}, got[t], 1);
    chk(rdat[t] == d, {req, " data"}, rdat[t], d);
    chk(rcyc[t] == c, {req, " cycle"}, rcyc[t], c);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int n, m, nr [8];
    for (int i = 0; i < 16; i++) begin got[i] = 0; rcyc[i] = 0; rdat[i] = '0; end
    idle(3);
    chk(ready == 1'b1, "R1 ready in reset", ready, 1);
    chk(rsp_valid == 1'b0, "R1 rsp in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1 && rsp_valid == 1'b0, "R1 after reset", {ready, rsp_valid}, 2);

    // R2 define four blocks at distinct bases
    define(0, 0, 7);
    define(1, 8, 3);
    define(2, 20, 15);
    define(3, 40, 0);

    // R4 R9 direct reads sweep
    for (int o = 0; o < 8; o++) wr(0, o, wd(0, o), n);
    for (int o = 0; o < 8; o++) rd(0, o, o, nr[o]);
    idle(LAT + 2);
    for (int o = 0; o < 8; o++) exp_rsp(o, wd(0, o), nr[o] + LAT, "R4 R9 direct");

    // R5 R8 park reads until the list is full
    for (int o = 0; o < 4; o++) rd(1, o, 8 + o, n);
    op = 2'd0;
    #1 chk(ready == 1'b0, "R8 read blocked", ready, 0);
    op = 2'd1;
    #1 chk(ready == 1'b1, "R8 write open", ready, 1);
    idle(LAT + 2);
    for (int o = 0; o < 3; o++) wr(1, o, wd(1, o), n);
    idle(LAT + 2);
    chk(rcount == 8, "R5 R3 no early response", rcount, 8);
    wr(1, 3, wd(1, 3), m);
    idle(LAT + 6);
    for (int o = 0; o < 4; o++) exp_rsp(8 + o, wd(1, o), m + 1 + o + LAT, "R6 R2 order");

    // R7 release beats a same-cycle read
    rd(2, 5, 12, n);
    for (int o = 0; o < 15; o++) wr(2, o, wd(2, o), n);
    idle(LAT + 1);
    chk(got[12] == 0, "R5 not full before last", got[12], 0);
    wr(2, 15, wd(2, 15), m);
    rd(0, 2, 13, n);
    idle(LAT + 4);
    exp_rsp(12, wd(2, 5), m + 1 + LAT, "R7 release");
    exp_rsp(13, wd(0, 2), m + 2 + LAT, "R7 queued behind");

    // R3 single-word block
    rd(3, 0, 14, n);
    idle(2);
    wr(3, 0, wd(3, 0), m);
    idle(LAT + 3);
    exp_rsp(14, wd(3, 0), m + 1 + LAT, "R3 length one");

    // R10 redefine empties a full block
    define(0, 0, 7);
    rd(0, 0, 15, n);
    idle(LAT + 3);
    chk(got[15] == 0, "R10 parked after redefine", got[15], 0);
    wr(0, 7, 16'hBEEF, m);
    idle(LAT + 3);
    exp_rsp(15, wd(0, 0), m + 1 + LAT, "R10 release");
    chk(rcount == 16, "R9 total responses", rcount, 16);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule